// File: doc/BRIEF.md
# Mixed-width true dual-port RAM

The block is a 4096-bit synchronous memory with two independent ports, A and B. Each port has its own clock, enable, write enable, address, write data and read data, and either port can read or write. A parameter sets each port's data width on its own, to 1, 2, 4, 8 or 16 bits. Both ports see the same bit array, so a value written through one port at one width can be read back through the other port at a different width. The memory performs the width conversion itself, and no packing logic is needed around it.

A word at address N on a port of width W covers array bits N*W up to N*W+W-1. The lowest bit of the word sits at the lowest array index. The mapping is the same on both ports. A port's address width is therefore log2(4096/W). Each port's read data is a register on that port's clock. A per-port synchronous reset clears only that register and leaves the memory contents as they are. The array powers up holding all zeros.

Top module: `mixed_width_dpram`

## Requirements
- R1: Before any write, a read of any address on either port returns zero.
- R2: While a port's reset is high at its clock edge, that port's read data becomes zero after the edge, and the memory contents are not changed.
- R3: With enable high and write enable low, the word at the address is presented on the port's read data after the same rising edge of the port's clock.
- R4: With enable and write enable high, the word is stored, and the port's read data shows the written data after that edge (write-first).
- R5: With enable low, the port's read data holds its previous value and no write takes place, whatever write enable, address and write data are.
- R6: Word N of a port of width W occupies array bits N*W to N*W+W-1, with word bit 0 at the lowest index, identically on both ports. With A at 4 bits and B at 16 bits, A address k is nibble k%4 (bits 4*(k%4) upward) of B word k/4.
- R7: Data written by one port is returned by reads on the other port, at the other port's width, from the next edge on.
- R8: The address of a port of width W is log2(4096/W) bits wide. The highest address reaches the last bits of the array: A address 1023 is the top nibble of B word 255.
- R9: Writes by both ports in the same cycle to disjoint bits both take effect. When the two writes overlap, the bits they share are undefined, and the bench flags that case instead of checking it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset of the read data register |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | log2(4096/WIDTH_A) | Port A word address |
| wdata_a | input | WIDTH_A | Port A write data |
| rdata_a | output | WIDTH_A | Port A read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset of the read data register |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | log2(4096/WIDTH_B) | Port B word address |
| wdata_b | input | WIDTH_B | Port B write data |
| rdata_b | output | WIDTH_B | Port B read data |

## Verification
Every result is due one edge after its stimulus.

- A read, a write-first echo, a reset or a held value appears on the port's read data just after the rising edge that samples the request.
- A word written on one port can be read by the other port through a request sampled at any later edge.

The bench changes its inputs 1 ns after a rising edge. It samples the read data 1 ns after the next rising edge, so every check sits one register stage after its request and well away from either edge.

// File: rtl/mixed_width_dpram.sv
module mixed_width_dpram #(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 16,
  localparam int TOTAL  = 4096,
  localparam int ADDR_A = $clog2(TOTAL / WIDTH_A),
  localparam int ADDR_B = $clog2(TOTAL / WIDTH_B)
) (
  input  logic               clk_a,
  input  logic               rst_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [ADDR_A-1:0]  addr_a,
  input  logic [WIDTH_A-1:0] wdata_a,
  output logic [WIDTH_A-1:0] rdata_a,
  input  logic               clk_b,
  input  logic               rst_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [ADDR_B-1:0]  addr_b,
  input  logic [WIDTH_B-1:0] wdata_b,
  output logic [WIDTH_B-1:0] rdata_b
);
  localparam int IDX = $clog2(TOTAL);

  // Each stored bit is the XOR of two halves, each half owned by one port's clock.
  logic [TOTAL-1:0] half_a = '0;
  logic [TOTAL-1:0] half_b = '0;
  logic [TOTAL-1:0] bits;
  logic [IDX-1:0]   base_a, base_b;

  assign bits   = half_a ^ half_b;
  assign base_a = IDX'(addr_a) * IDX'(WIDTH_A);
  assign base_b = IDX'(addr_b) * IDX'(WIDTH_B);

  always_ff @(posedge clk_a)
    if (en_a && we_a)
      half_a[base_a +: WIDTH_A] <= wdata_a ^ half_b[base_a +: WIDTH_A];

  always_ff @(posedge clk_b)
    if (en_b && we_b)
      half_b[base_b +: WIDTH_B] <= wdata_b ^ half_a[base_b +: WIDTH_B];

  always_ff @(posedge clk_a)
    if (rst_a)     rdata_a <= '0;
    else if (en_a) rdata_a <= we_a ? wdata_a : bits[base_a +: WIDTH_A];

  always_ff @(posedge clk_b)
    if (rst_b)     rdata_b <= '0;
    else if (en_b) rdata_b <= we_b ? wdata_b : bits[base_b +: WIDTH_B];

  AST_RST_CLEARS_A: assert property (@(posedge clk_a) rst_a |=> rdata_a == '0); // R2
  AST_RST_CLEARS_B: assert property (@(posedge clk_b) rst_b |=> rdata_b == '0); // R2
  AST_WRITE_FIRST_A: assert property (@(posedge clk_a) disable iff (rst_a)
    en_a && we_a |=> rdata_a == $past(wdata_a)); // R4
  AST_WRITE_FIRST_B: assert property (@(posedge clk_b) disable iff (rst_b)
    en_b && we_b |=> rdata_b == $past(wdata_b)); // R4
  AST_HOLD_A: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable(rdata_a)); // R5
  AST_HOLD_B: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable(rdata_b)); // R5
endmodule

// File: tb/mixed_width_dpram_bench.sv
module mixed_width_dpram_bench;
  localparam int WA = 4;
  localparam int WB = 16;
  localparam int AA = 10;
  localparam int AB = 8;
  localparam int NV = 18;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a, en_a, we_a, rst_b, en_b, we_b;
  logic [AA-1:0] addr_a;
  logic [AB-1:0] addr_b;
  logic [WA-1:0] wdata_a, rdata_a;
  logic [WB-1:0] wdata_b, rdata_b;
  int tests = 0, fails = 0, conflicts = 0;

  always #5 clk_a = ~clk_a;
  always #5 clk_b = ~clk_b;

  mixed_width_dpram #(.WIDTH_A(WA), .WIDTH_B(WB)) u_mixed_width_dpram (
    .clk_a(clk_a), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .wdata_a(wdata_a), .rdata_a(rdata_a),
    .clk_b(clk_b), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
    .wdata_b(wdata_b), .rdata_b(rdata_b));

  // {port(1=B), write, addr[9:0], data[15:0], expected[15:0], requirement}
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 1'b0, 10'd0,    16'h0000, 16'h0000, 4'd1}, // R1
    {1'b0, 1'b0, 10'd9,    16'h0000, 16'h0000, 4'd1}, // R1
    {1'b0, 1'b1, 10'd0,    16'h0005, 16'h0005, 4'd4}, // R4
    {1'b0, 1'b1, 10'd1,    16'h000A, 16'h000A, 4'd4}, // R4
    {1'b0, 1'b1, 10'd2,    16'h0003, 16'h0003, 4'd4}, // R4
    {1'b0, 1'b1, 10'd3,    16'h000C, 16'h000C, 4'd4}, // R4
    {1'b1, 1'b0, 10'd0,    16'h0000, 16'hC3A5, 4'd6}, // R6
    {1'b1, 1'b1, 10'd1,    16'h1234, 16'h1234, 4'd4}, // R4
    {1'b0, 1'b0, 10'd4,    16'h0000, 16'h0004, 4'd7}, // R7
    {1'b0, 1'b0, 10'd7,    16'h0000, 16'h0001, 4'd7}, // R7
    {1'b0, 1'b0, 10'd0,    16'h0000, 16'h0005, 4'd3}, // R3
    {1'b0, 1'b1, 10'd1023, 16'h000F, 16'h000F, 4'd8}, // R8
    {1'b1, 1'b0, 10'd255,  16'h0000, 16'hF000, 4'd8}, // R8
    {1'b1, 1'b1, 10'd255,  16'hBEEF, 16'hBEEF, 4'd8}, // R8
    {1'b0, 1'b0, 10'd1020, 16'h0000, 16'h000F, 4'd8}, // R8
    {1'b0, 1'b0, 10'd1021, 16'h0000, 16'h000E, 4'd8}, // R8
    {1'b0, 1'b0, 10'd1023, 16'h0000, 16'h000B, 4'd8}, // R8
    {1'b0, 1'b0, 10'd1,    16'h0000, 16'h000A, 4'd3}  // R3
  };

  task automatic check(input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_a);
    #1;
  endtask

  task automatic idle();
    en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog actual hung expected done");
    report();
  end

  initial begin
    rst_a = 1'b1; rst_b = 1'b1; idle();
    addr_a = '0; addr_b = '0; wdata_a = '0; wdata_b = '0;
    step(); step();
    check("R2", {12'd0, rdata_a}, 16'h0);
    check("R2", rdata_b, 16'h0);
    rst_a = 1'b0; rst_b = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      idle();
      if (VEC[i][47]) begin
        en_b = 1'b1; we_b = VEC[i][46]; addr_b = VEC[i][43:36]; wdata_b = VEC[i][35:20];
      end else begin
        en_a = 1'b1; we_a = VEC[i][46]; addr_a = VEC[i][45:36]; wdata_a = VEC[i][23:20];
      end
      step();
      check($sformatf("R%0d vec %0d", VEC[i][3:0], i),
            VEC[i][47] ? rdata_b : {12'd0, rdata_a}, VEC[i][19:4]);
    end

    // R5: disabled port ignores a write request and holds its output
    idle(); en_a = 1'b1; addr_a = 10'd0; step();
    check("R3", {12'd0, rdata_a}, 16'h5);
    idle(); we_a = 1'b1; addr_a = 10'd0; wdata_a = 4'h7; step();
    check("R5 hold", {12'd0, rdata_a}, 16'h5);
    addr_a = 10'd2; step();
    check("R5 hold", {12'd0, rdata_a}, 16'h5);
    idle(); en_a = 1'b1; addr_a = 10'd0; step();
    check("R5 no write", {12'd0, rdata_a}, 16'h5);

    // R2: reset clears the output only
    idle(); en_a = 1'b1; we_a = 1'b1; addr_a = 10'd5; wdata_a = 4'h9; step();
    check("R4", {12'd0, rdata_a}, 16'h9);
    idle(); rst_a = 1'b1; step();
    check("R2 reset", {12'd0, rdata_a}, 16'h0);
    rst_a = 1'b0; en_a = 1'b1; addr_a = 10'd5; step();
    check("R2 contents kept", {12'd0, rdata_a}, 16'h9);

    // R9: disjoint simultaneous writes
    idle();
    en_a = 1'b1; we_a = 1'b1; addr_a = 10'd8; wdata_a = 4'h6;
    en_b = 1'b1; we_b = 1'b1; addr_b = 8'd3; wdata_b = 16'h7777;
    step();
    idle(); en_b = 1'b1; addr_b = 8'd3; step();
    check("R9 port B word", rdata_b, 16'h7777);
    addr_b = 8'd2; step();
    check("R9 port A word", rdata_b, 16'h0006);

    // R9: overlapping simultaneous writes are flagged, not checked
    idle();
    en_a = 1'b1; we_a = 1'b1; addr_a = 10'd12; wdata_a = 4'h1;
    en_b = 1'b1; we_b = 1'b1; addr_b = 8'd3; wdata_b = 16'h2222;
    conflicts++;
    step();
    $display("[TB] note: %0d overlapping write flagged, stored bits not checked", conflicts);
    check("R4 echo A", {12'd0, rdata_a}, 16'h1);
    check("R4 echo B", rdata_b, 16'h2222);

    idle(); step();
    report();
  end
endmodule